// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block supplies the next fetch address for an instruction fetch stage. Each cycle the fetch PC probes a direct-mapped table, and the result arrives in that same cycle. A table entry records the upper address bits of a branch, the address the branch jumped to, and a 2-bit saturating confidence counter. When the probe finds a valid entry whose stored upper bits equal those of the fetch PC, and the counter leans taken, the stored target becomes the next fetch PC. Every other case falls through to the sequential address, fetch PC plus 4.

Resolved branches come back through an update port, one per cycle. A taken branch installs its entry or refreshes it. A not-taken branch that finds its own entry weakens that entry's counter. The number of entries (a power of two) and the address width are parameters.

Top module: `btb`

## Requirements
- R1: After reset every entry is invalid, so every probe reports `pred_hit`=0 and `pred_next_pc` = `fetch_pc`+4.
- R2: When a probe misses, `pred_hit`=0, `pred_taken`=0 and `pred_next_pc` = `fetch_pc`+4, all in the same cycle as the probe.
- R3: A hit needs the whole stored tag to equal the tag of the fetch PC. A PC with the same index but a different tag misses.
- R4: A hit whose counter is 2 or 3 gives `pred_taken`=1, and in the same cycle `pred_next_pc` equals the stored target.
- R5: A hit whose counter is 0 or 1 gives `pred_hit`=1 and `pred_taken`=0, with `pred_next_pc` = `fetch_pc`+4.
- R6: A taken update that misses installs the entry with counter 2. A taken update that hits increments the counter (it saturates at 3) and overwrites the target.
- R7: A not-taken update that hits decrements the counter (it saturates at 0) and keeps the target. A not-taken update that misses changes nothing.
- R8: A probe and an update to the same index in the same cycle see the old entry. The new entry is visible from the next cycle.
- R9: The index is PC bits [log2(DEPTH)+1:2] and the tag is the PC bits above the index. Bits [1:0] play no part in the hit decision, so an entry written through one index replaces any entry that held that index before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | PC probed this cycle |
| pred_hit | output | 1 | Valid entry with a matching tag was found |
| pred_taken | output | 1 | Hit and the counter leans taken |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | ADDR_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
The probe outputs are combinational from `fetch_pc` and the stored table, so they are due in the cycle the PC is applied. An update lands at the next rising edge and shows up in probes from the cycle that follows. The bench drives every input just after a falling edge and samples the outputs 1 ns later, inside the same low phase. An update is held for exactly one rising edge, and the probe that checks it is taken after the next falling edge. The same-cycle case sets the update and the probe to one index in the same low phase and checks the old entry before the edge, then the new entry after it.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam logic [1:0] CNT_INSTALL = 2'b10;

    function automatic logic [1:0] cnt_up(input logic [1:0] c);
        return (c == 2'b11) ? c : c + 2'd1;
    endfunction

    function automatic logic [1:0] cnt_down(input logic [1:0] c);
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

    function automatic logic cnt_says_taken(input logic [1:0] c);
        return c[1];
    endfunction

endpackage

// File: rtl/btb_split.sv
module btb_split #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - IDX_W - 2
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    logic unused_offset;

    assign idx           = pc[IDX_W+1:2];
    assign tag           = pc[ADDR_W-1:IDX_W+2];
    assign unused_offset = ^pc[1:0];
endmodule

// File: rtl/btb_store.sv
module btb_store #(
    parameter int DEPTH  = 16,
    parameter int TAG_W  = 26,
    parameter int TGT_W  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic             rd_valid_a,
    output logic [TAG_W-1:0] rd_tag_a,
    output logic [TGT_W-1:0] rd_tgt_a,
    output logic [1:0]       rd_cnt_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic             rd_valid_b,
    output logic [TAG_W-1:0] rd_tag_b,
    output logic [TGT_W-1:0] rd_tgt_b,
    output logic [1:0]       rd_cnt_b,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic [1:0]       wr_cnt
);
    typedef struct packed {
        logic [DEPTH-1:0]            valid;
        logic [DEPTH-1:0][TAG_W-1:0] tag;
        logic [DEPTH-1:0][TGT_W-1:0] tgt;
        logic [DEPTH-1:0][1:0]       cnt;
    } table_t;

    table_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (we) begin
            tbl_d.valid[wr_idx] = 1'b1;
            tbl_d.tag[wr_idx]   = wr_tag;
            tbl_d.tgt[wr_idx]   = wr_tgt;
            tbl_d.cnt[wr_idx]   = wr_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    // reads see registered contents only: same-cycle write is not forwarded
    assign rd_valid_a = tbl_q.valid[rd_idx_a];
    assign rd_tag_a   = tbl_q.tag[rd_idx_a];
    assign rd_tgt_a   = tbl_q.tgt[rd_idx_a];
    assign rd_cnt_a   = tbl_q.cnt[rd_idx_a];
    assign rd_valid_b = tbl_q.valid[rd_idx_b];
    assign rd_tag_b   = tbl_q.tag[rd_idx_b];
    assign rd_tgt_b   = tbl_q.tgt[rd_idx_b];
    assign rd_cnt_b   = tbl_q.cnt[rd_idx_b];

    assert_install_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> tbl_q.valid[$past(wr_idx)]);

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (tbl_q.tgt[$past(wr_idx)] == $past(wr_tgt)) &&
               (tbl_q.cnt[$past(wr_idx)] == $past(wr_cnt)));

    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(tbl_q));
endmodule

// File: rtl/btb_update.sv
module btb_update
    import btb_pkg::*;
#(
    parameter int TAG_W = 26,
    parameter int TGT_W = 32
) (
    input  logic             upd_valid,
    input  logic             upd_taken,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic [TGT_W-1:0] upd_target,
    input  logic             cur_valid,
    input  logic [TAG_W-1:0] cur_tag,
    input  logic [TGT_W-1:0] cur_tgt,
    input  logic [1:0]       cur_cnt,
    output logic             we,
    output logic [TGT_W-1:0] wr_tgt,
    output logic [1:0]       wr_cnt
);
    logic upd_hit;

    assign upd_hit = cur_valid && (cur_tag == upd_tag);

    always_comb begin
        we     = 1'b0;
        wr_tgt = cur_tgt;
        wr_cnt = cur_cnt;
        if (upd_valid) begin
            if (upd_taken) begin
                we     = 1'b1;
                wr_tgt = upd_target;
                wr_cnt = upd_hit ? cnt_up(cur_cnt) : CNT_INSTALL;
            end else if (upd_hit) begin
                we     = 1'b1;
                wr_cnt = cnt_down(cur_cnt);
            end
        end
    end
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 26
) (
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [TAG_W-1:0]  fetch_tag,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [ADDR_W-1:0] ent_tgt,
    input  logic [1:0]        ent_cnt,
    output logic              hit,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc
);
    always_comb begin
        hit     = ent_valid && (ent_tag == fetch_tag);
        taken   = hit && cnt_says_taken(ent_cnt);
        next_pc = taken ? ent_tgt : fetch_pc + ADDR_W'(4);
    end
endmodule

// File: rtl/btb.sv
module btb #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_next_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int TAG_W = ADDR_W - IDX_W - 2;

    logic [IDX_W-1:0]  f_idx, u_idx;
    logic [TAG_W-1:0]  f_tag, u_tag;
    logic              a_valid, b_valid;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [ADDR_W-1:0] a_tgt, b_tgt;
    logic [1:0]        a_cnt, b_cnt;
    logic              we;
    logic [ADDR_W-1:0] wr_tgt;
    logic [1:0]        wr_cnt;

    btb_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split_f (
        .pc(fetch_pc), .idx(f_idx), .tag(f_tag));

    btb_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split_u (
        .pc(upd_pc), .idx(u_idx), .tag(u_tag));

    btb_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .TGT_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx_a(f_idx), .rd_valid_a(a_valid), .rd_tag_a(a_tag),
        .rd_tgt_a(a_tgt), .rd_cnt_a(a_cnt),
        .rd_idx_b(u_idx), .rd_valid_b(b_valid), .rd_tag_b(b_tag),
        .rd_tgt_b(b_tgt), .rd_cnt_b(b_cnt),
        .we(we), .wr_idx(u_idx), .wr_tag(u_tag), .wr_tgt(wr_tgt), .wr_cnt(wr_cnt));

    btb_update #(.TAG_W(TAG_W), .TGT_W(ADDR_W)) u_update (
        .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_tag(u_tag),
        .upd_target(upd_target), .cur_valid(b_valid), .cur_tag(b_tag),
        .cur_tgt(b_tgt), .cur_cnt(b_cnt),
        .we(we), .wr_tgt(wr_tgt), .wr_cnt(wr_cnt));

    btb_lookup #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_lookup (
        .fetch_pc(fetch_pc), .fetch_tag(f_tag),
        .ent_valid(a_valid), .ent_tag(a_tag), .ent_tgt(a_tgt), .ent_cnt(a_cnt),
        .hit(pred_hit), .taken(pred_taken), .next_pc(pred_next_pc));

    assert_seq_on_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (pred_next_pc == fetch_pc + ADDR_W'(4)) && !pred_taken);

    assert_taken_only_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit);

    assert_nt_miss_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && !(b_valid && b_tag == u_tag)) |-> !we);
endmodule

// File: tb/btb_tb.sv
module btb_tb;
    localparam int ADDR_W = 32;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] fetch_pc = '0;
    logic              pred_hit, pred_taken;
    logic [ADDR_W-1:0] pred_next_pc;
    logic              upd_valid = 1'b0;
    logic [ADDR_W-1:0] upd_pc = '0;
    logic              upd_taken = 1'b0;
    logic [ADDR_W-1:0] upd_target = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    btb #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target));

    // index = pc[5:2], tag = pc[31:6] for DEPTH=16
    localparam logic [31:0] PC_A  = 32'h0000_1044; // idx 1
    localparam logic [31:0] PC_B  = 32'h0000_2044; // idx 1, other tag
    localparam logic [31:0] PC_C  = 32'h0000_100C; // idx 3
    localparam logic [31:0] TGT_1 = 32'h0000_8000;
    localparam logic [31:0] TGT_2 = 32'h0000_9100;
    localparam logic [31:0] TGT_3 = 32'h0000_A200;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // called in the low phase; samples 1 ns after applying the PC
    task automatic probe(input string req, input logic [31:0] pc,
                         input logic eh, input logic et, input logic [31:0] en);
        fetch_pc = pc;
        #1;
        check(req, "hit", {31'b0, pred_hit}, {31'b0, eh});
        check(req, "taken", {31'b0, pred_taken}, {31'b0, et});
        check(req, "next_pc", pred_next_pc, en);
    endtask

    task automatic update(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic t_reset;
        probe("R1", PC_A, 0, 0, PC_A + 4);
        probe("R1", PC_C, 0, 0, PC_C + 4);
        probe("R2", 32'hFFFF_FFFC, 0, 0, 32'h0000_0000);
    endtask

    task automatic t_counter;
        update(PC_A, 1, TGT_1);                 // install, counter 2
        probe("R6", PC_A, 1, 1, TGT_1);
        probe("R4", PC_A, 1, 1, TGT_1);
        update(PC_A, 0, 32'h0);                 // 2 -> 1
        probe("R5", PC_A, 1, 0, PC_A + 4);
        update(PC_A, 1, TGT_1);                 // 1 -> 2
        probe("R6", PC_A, 1, 1, TGT_1);
        update(PC_A, 1, TGT_1);                 // 3
        update(PC_A, 1, TGT_1);                 // stays 3
        update(PC_A, 0, 32'h0);                 // 2 only if saturated at 3
        probe("R6", PC_A, 1, 1, TGT_1);
        update(PC_A, 0, 32'h0);                 // 1
        probe("R7", PC_A, 1, 0, PC_A + 4);
        update(PC_A, 0, 32'h0);                 // 0
        update(PC_A, 0, 32'h0);                 // stays 0
        update(PC_A, 1, TGT_2);                 // 1, target rewritten
        probe("R7", PC_A, 1, 0, PC_A + 4);
        update(PC_A, 1, TGT_2);                 // 2
        probe("R6", PC_A, 1, 1, TGT_2);
    endtask

    task automatic t_alias;
        probe("R3", PC_B, 0, 0, PC_B + 4);
        update(PC_B, 0, 32'h0);                 // not-taken miss: no change
        probe("R7", PC_A, 1, 1, TGT_2);
        update(PC_B, 1, TGT_3);                 // replaces PC_A's entry
        probe("R9", PC_B, 1, 1, TGT_3);
        probe("R9", PC_A, 0, 0, PC_A + 4);
        probe("R9", PC_B | 32'h3, 1, 1, TGT_3); // offset bits ignored
    endtask

    task automatic t_same_cycle;
        upd_valid = 1'b1; upd_pc = PC_C; upd_taken = 1'b1; upd_target = TGT_1;
        probe("R8", PC_C, 0, 0, PC_C + 4);      // old contents before the edge
        @(negedge clk);
        upd_valid = 1'b0;
        probe("R8", PC_C, 1, 1, TGT_1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_counter();
        t_alias();
        t_same_cycle();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule